// File: doc/BRIEF.md
# Configurable Word Bit-Swap Unit

This block carries out the data path of a processor's swap instruction. A four-bit control field turns on any mix of four transforms on one operand word: a bitwise complement of the whole word, an exchange of the two half-words, an exchange of the two bytes inside each half-word, and a reversal of the bit order inside each byte. The enabled transforms are applied one after another in a fixed order. The bytes themselves stay in place during the bit reversal.

The transformed word leaves the block one clock after it was presented, along with a valid strobe. Two condition flags come with it: negative, which is the most significant result bit, and zero, which is set when every result bit is clear. Register-file access, instruction decoding and the other condition flags all stay with the surrounding core. The core writes the result back to the register that supplied the operand and merges the two flags into its status word.

Top module: `wbs_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted word, `out_valid`, `out_word`, `out_neg` and `out_zero` are all 0.
- R2: With `in_ctrl` = 4'b0000, the output word equals the input word.
- R3: `in_ctrl` bit 3 (value 8) complements every bit of the word.
- R4: `in_ctrl` bit 2 (value 4) exchanges bits [31:16] with bits [15:0].
- R5: `in_ctrl` bit 1 (value 2) exchanges the two bytes inside each 16-bit half, so the result is ((x << 8) & 32'hFF00FF00) | ((x >> 8) & 32'h00FF00FF).
- R6: `in_ctrl` bit 0 (value 1) reverses the bit order inside each of the four bytes and leaves every byte at its own position.
- R7: The enabled stages are applied in the order complement, half-word exchange, byte exchange, bit reversal, for every one of the 16 control values.
- R8: `out_neg` equals bit 31 of the result, and `out_zero` is 1 exactly when the result is all zeros.
- R9: `out_valid` is 1 in the cycle after each cycle in which `in_valid` is 1, and 0 otherwise. Words presented on consecutive cycles each give a result on consecutive cycles.
- R10: While `in_valid` is 0, `out_word`, `out_neg` and `out_zero` keep their previous values, whatever `in_word` and `in_ctrl` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and control are presented this cycle |
| in_word | input | 32 | Operand word |
| in_ctrl | input | 4 | Transform enables: bit 3 complement, bit 2 half exchange, bit 1 byte exchange, bit 0 bit reversal |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_word | output | 32 | Transformed word |
| out_neg | output | 1 | Result bit 31 |
| out_zero | output | 1 | Result is zero |

## Verification
The bench uses asymmetric operands such as 32'h12345678, so that confusing the byte exchange with the half exchange, or reversing the bits across the whole word instead of inside each byte, gives a visibly wrong word. Every control value is compared against an independent ordered model. Single-bit operands (bit 0, bit 15, bit 31) check that a bit lands in the right byte and that the negative flag follows it. A design that computed the flags from the operand rather than the result would fail the complement-to-zero case. Idle cycles with changing inputs, followed by a mid-run reset, catch a register that loads without a valid strobe or that does not clear.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   // Bit positions of the transform enables inside the control field.
   localparam int CTRL_W      = 4;
   localparam int CB_REVERSE  = 0;
   localparam int CB_BYTESWAP = 1;
   localparam int CB_HALFSWAP = 2;
   localparam int CB_INVERT   = 3;

   localparam int LANE_W  = 8;   // bit reversal granule
   localparam int PAIR_W  = 16;  // byte exchange granule
   localparam int N_STAGE = 4;

   typedef enum logic [1:0] {
      ST_INVERT   = 2'd0,
      ST_HALFSWAP = 2'd1,
      ST_BYTESWAP = 2'd2,
      ST_REVERSE  = 2'd3
   } stage_e;

   // Application order: position 0 is applied first.
   function automatic stage_e stage_at(input int pos);
      case (pos)
         0:       return ST_INVERT;
         1:       return ST_HALFSWAP;
         2:       return ST_BYTESWAP;
         default: return ST_REVERSE;
      endcase
   endfunction

   function automatic int ctrl_bit_of(input stage_e k);
      case (k)
         ST_INVERT:   return CB_INVERT;
         ST_HALFSWAP: return CB_HALFSWAP;
         ST_BYTESWAP: return CB_BYTESWAP;
         default:     return CB_REVERSE;
      endcase
   endfunction

endpackage

// File: rtl/wbs_stage.sv
// One optional transform of the chain; KIND picks which one.
module wbs_stage
   import wbs_pkg::*;
#(
   parameter int     DATA_W = 32,
   parameter stage_e KIND   = ST_INVERT
) (
   input  logic              enable,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   localparam int HALF_W  = DATA_W / 2;
   localparam int N_LANE  = DATA_W / LANE_W;
   localparam int N_PAIR  = DATA_W / PAIR_W;
   localparam int BYTE_W  = PAIR_W / 2;

   logic [DATA_W-1:0] moved;

   generate
      case (KIND)
         ST_INVERT: begin : g_inv
            assign moved = ~din;
         end
         ST_HALFSWAP: begin : g_half
            assign moved = {din[HALF_W-1:0], din[DATA_W-1:HALF_W]};
         end
         ST_BYTESWAP: begin : g_byte
            for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
               assign moved[p*PAIR_W +: BYTE_W]          = din[p*PAIR_W + BYTE_W +: BYTE_W];
               assign moved[p*PAIR_W + BYTE_W +: BYTE_W] = din[p*PAIR_W +: BYTE_W];
            end
         end
         default: begin : g_rev
            for (genvar l = 0; l < N_LANE; l++) begin : g_lane
               for (genvar b = 0; b < LANE_W; b++) begin : g_bit
                  assign moved[l*LANE_W + b] = din[l*LANE_W + (LANE_W-1-b)];
               end
            end
         end
      endcase
   endgenerate

   assign dout = enable ? moved : din;

endmodule

// File: rtl/wbs_flags.sv
// Condition flags taken from a finished result word.
module wbs_flags #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] word,
   output logic              neg,
   output logic              zero
);

   assign neg  = word[DATA_W-1];
   assign zero = ~|word;

endmodule

// File: rtl/wbs_unit.sv
module wbs_unit
   import wbs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_word,
   input  logic [CTRL_W-1:0] in_ctrl,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_word,
   output logic              out_neg,
   output logic              out_zero
);

   generate
      if (DATA_W < PAIR_W || (DATA_W % PAIR_W) != 0) begin : g_bad_width
         $error("wbs_unit: DATA_W must be a positive multiple of %0d", PAIR_W);
      end
   endgenerate

   logic [DATA_W-1:0] chain [N_STAGE+1];
   assign chain[0] = in_word;

   generate
      for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
         localparam stage_e KIND = stage_at(s);
         localparam int     CBIT = ctrl_bit_of(KIND);
         wbs_stage #(.DATA_W(DATA_W), .KIND(KIND)) u_stage (
            .enable (in_ctrl[CBIT]),
            .din    (chain[s]),
            .dout   (chain[s+1])
         );
      end
   endgenerate

   logic neg_d, zero_d;

   wbs_flags #(.DATA_W(DATA_W)) u_flags (
      .word (chain[N_STAGE]),
      .neg  (neg_d),
      .zero (zero_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_neg   <= 1'b0;
         out_zero  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= chain[N_STAGE];
            out_neg  <= neg_d;
            out_zero <= zero_d;
         end
      end
   end

endmodule

// File: rtl/wbs_unit_chk.sv
module wbs_unit_chk
   import wbs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_word,
   input logic [CTRL_W-1:0] in_ctrl,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_word,
   input logic              out_neg,
   input logic              out_zero
);

   // R2
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ctrl == '0) |=> out_word == $past(in_word));

   // R3
   invert_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ctrl == 4'b1000) |=> out_word == ~$past(in_word));

   // R8
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_neg == out_word[DATA_W-1]);

   // R8
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_zero == (out_word == '0));

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_word) && $stable(out_neg) && $stable(out_zero)));

endmodule

bind wbs_unit wbs_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_word   (in_word),
   .in_ctrl   (in_ctrl),
   .out_valid (out_valid),
   .out_word  (out_word),
   .out_neg   (out_neg),
   .out_zero  (out_zero)
);

// File: tb/sim_wbs_unit.sv
`timescale 1ns/1ps
module sim_wbs_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic [3:0]  in_ctrl = '0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_neg;
   logic        out_zero;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   wbs_unit #(.DATA_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_ctrl(in_ctrl), .out_valid(out_valid), .out_word(out_word),
      .out_neg(out_neg), .out_zero(out_zero)
   );

   // {ctrl, operand, expected result}
   localparam int NV = 14;
   localparam logic [67:0] VEC [NV] = '{
      {4'h0, 32'h12345678, 32'h12345678},
      {4'h8, 32'h12345678, 32'hEDCBA987},
      {4'h4, 32'h12345678, 32'h56781234},
      {4'h2, 32'h12345678, 32'h34127856},
      {4'h1, 32'h12345678, 32'h482C6A1E},
      {4'h6, 32'h12345678, 32'h78563412},
      {4'h7, 32'h12345678, 32'h1E6A2C48},
      {4'hF, 32'h12345678, 32'hE195D3B7},
      {4'h8, 32'hFFFFFFFF, 32'h00000000},
      {4'h1, 32'h00000001, 32'h00000080},
      {4'h4, 32'h00008000, 32'h80000000},
      {4'h9, 32'hFFFFFFFE, 32'h00000080},
      {4'hE, 32'h00FF00FF, 32'h00FF00FF},
      {4'h3, 32'h80000000, 32'h00010000}
   };

   // Ordered model: complement, half exchange, byte exchange, bit reversal.
   function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] x);
      logic [31:0] y;
      y = x;
      if (c[3]) y = y ^ 32'hFFFFFFFF;
      if (c[2]) y = (y << 16) | (y >> 16);
      if (c[1]) y = ((y << 8) & 32'hFF00FF00) | ((y >> 8) & 32'h00FF00FF);
      if (c[0]) begin
         logic [31:0] r;
         r = '0;
         for (int i = 0; i < 32; i++) r[(i/8)*8 + 7 - (i%8)] = y[i];
         y = r;
      end
      return y;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drive, then check at the next falling edge.
   task automatic apply(input string req, input logic [3:0] c,
                        input logic [31:0] x, input logic [31:0] exp);
      in_valid = 1'b1;
      in_ctrl  = c;
      in_word  = x;
      @(negedge clk);
      chk({req, " word"}, out_word, exp);
      chk("R8 neg", {31'b0, out_neg}, {31'b0, exp[31]});
      chk("R8 zero", {31'b0, out_zero}, {31'b0, exp == 32'h0});
      chk("R9 valid", {31'b0, out_valid}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 valid in reset", {31'b0, out_valid}, 32'd0);
      chk("R1 word in reset", out_word, 32'd0);
      chk("R1 flags in reset", {30'b0, out_neg, out_zero}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 word after release", out_word, 32'd0);
      chk("R1 valid after release", {31'b0, out_valid}, 32'd0);

      // Vector table, words back to back (R2..R7, R8, R9)
      for (int v = 0; v < NV; v++) begin
         apply("R7 vector", VEC[v][67:64], VEC[v][63:32], VEC[v][31:0]);
      end

      // Every control value against the ordered model (R7)
      for (int c = 0; c < 16; c++) begin
         apply("R7 sweep", 4'(c), 32'hA5C30F81, model(4'(c), 32'hA5C30F81));
         apply("R7 sweep2", 4'(c), 32'h00000001, model(4'(c), 32'h00000001));
      end

      // Single transforms on other operands (R2..R6)
      apply("R2 identity", 4'h0, 32'h80000001, 32'h80000001);
      apply("R3 complement", 4'h8, 32'h0F0F0000, 32'hF0F0FFFF);
      apply("R4 half exchange", 4'h4, 32'hABCD0000, 32'h0000ABCD);
      apply("R5 byte exchange", 4'h2, 32'h0000FF00, 32'h000000FF);
      apply("R6 bit reversal", 4'h1, 32'h80010000, 32'h01800000);

      // Idle cycles with changing inputs: no load (R9, R10)
      held = out_word;
      in_valid = 1'b0;
      in_ctrl  = 4'hF;
      in_word  = 32'hDEADBEEF;
      @(negedge clk);
      chk("R9 valid drops", {31'b0, out_valid}, 32'd0);
      chk("R10 word held", out_word, held);
      in_word = 32'h00000000;
      in_ctrl = 4'h8;
      @(negedge clk);
      chk("R10 word still held", out_word, held);
      chk("R10 flags held", {30'b0, out_neg, out_zero}, {30'b0, held[31], held == 32'h0});

      // Single accepted word gives a single valid pulse (R9)
      apply("R9 single", 4'h8, 32'h00000000, 32'hFFFFFFFF);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R9 one pulse", {31'b0, out_valid}, 32'd0);

      // Mid-run reset clears everything (R1)
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset word", out_word, 32'd0);
      chk("R1 mid reset flags", {30'b0, out_neg, out_zero}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      apply("R2 after reset", 4'h0, 32'h00000000, 32'h00000000);
      in_valid = 1'b0;
      @(negedge clk);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule